// File: doc/BRIEF.md
# Keyed Two-Step Deadman Watchdog

This block is a deadman timer reached through a small memory-mapped register port. Once software turns it on, it counts clock cycles toward a programmable limit. To keep the system alive, software has to service it with two ordered key writes to two separate registers. The first write arms the sequence. The second write is accepted only while a status-flagged service window is open near the end of the count. A correct sequence returns the count to zero.

A service attempt with the wrong key, in the wrong order, or too early does not restart the count. Instead it latches a distinct error flag, which software can inspect afterwards. If the count reaches the limit, the block raises a one-cycle reset request for an external reset controller. It also records the cause in a flag that survives disabling and is cleared only by an explicit clear-alias write.

The on bit in the control word has set and clear aliases, so software can change it without a read-modify-write. Register reads return their value in the same cycle the address is presented.

Top module: `deadman_wdt`

## Requirements
- R1: After reset the control word reads 0, the counter (0x40) reads 0, the status (0x30) reads 0, the limit (0x60) reads 1000, the window length (0x70) reads 100, the cause word (0x80) reads 0, and `timeout_req` is low.
- R2: The on bit is bit 15 of the control word. A write to 0x00 loads it from wdata bit 15. A write to 0x08 sets it when wdata bit 15 is 1. A write to 0x04 clears it when wdata bit 15 is 1. A 0 in bit 15 of either alias leaves it unchanged. Reads of 0x00 return the on bit at bit 15.
- R3: While the block is on, the counter advances by one every clock. Turning it off returns the counter to 0 and clears status bits 0, 5, 6 and 7.
- R4: A write to 0x10 with wdata[15:8] = 0x40 arms the sequence. A following write to 0x20 with wdata[7:0] = 0x08, made while armed and while the window is open, sets the counter to 0 and disarms, with no error flag.
- R5: Status bit 0 is 1 exactly while the block is on and limit − window ≤ count < limit. The lower bound is 0 when window ≥ limit.
- R6: A count equal to the limit makes `timeout_req` high for the next clock only. In that same cycle it sets status bit 5 and cause bit 5 (0x80 reads 0x20), and the counter restarts from 0.
- R7: Status bit 7 is set by any of three events: a 0x20 write with a wrong key, a 0x20 write while not armed, or a 0x10 write whose wdata[15:8] is not 0x40. Such a 0x20 write does not reset the counter.
- R8: A correct 0x20 key while armed but outside the window sets status bit 6, leaves the counter running, and consumes the armed state.
- R9: Status bits 5, 6 and 7 stay set while the block is on, even across a later valid service. Turning the block off clears them.
- R10: Key writes to 0x10 and 0x20 made while the block is off arm nothing and set no flag.
- R11: A write to 0x84 with wdata bit 5 = 1 clears the cause flag. A write with bit 5 = 0 leaves it. Turning the block off does not clear it. The cause flag drives `reset_cause`.
- R12: The limit (0x60) and window length (0x70) registers are read-write over the full counter width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| timeout_req | output | 1 | One-cycle reset request on timeout |
| reset_cause | output | 1 | Sticky flag: the last reset request came from this timer |

## Verification
The service path is tried with several input patterns:
- a correct sequence inside the window, which restarts the count with no flag;
- a correct key that arrives before the window opens, which separates error flag 6 from flag 7;
- a missing pre-clear, a wrong pre-clear key and a wrong clear key, each of which must give flag 7 only;
- a sequence whose first step is written while the block is off, to show that such writes are ignored.

An unserviced run checks that the reset pulse lands one cycle after the limit and that the cause flag persists. A window wider than the limit checks the lower-bound clamp. Seeded random mixes of limits, window lengths, key writes and on/off toggles are then compared cycle by cycle against a reference model in the bench.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL_SET  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PRECLR    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR       = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT      = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CNT       = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_LIMIT     = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_WIN       = 8'h70;
  localparam logic [ADDR_W-1:0] OFS_CAUSE     = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CAUSE_CLR = 8'h84;

  localparam int BIT_ON    = 15;
  localparam int BIT_WIN   = 0;
  localparam int BIT_EVT   = 5;
  localparam int BIT_BAD2  = 6;
  localparam int BIT_BAD1  = 7;
  localparam int BIT_CAUSE = 5;

  localparam logic [7:0] KEY_PRE = 8'h40;
  localparam logic [7:0] KEY_CLR = 8'h08;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_CTRL_WR,
    ACC_CTRL_CLR,
    ACC_CTRL_SET,
    ACC_PRECLR,
    ACC_CLR,
    ACC_LIMIT,
    ACC_WIN,
    ACC_CAUSE_CLR
  } wr_kind_e;

  typedef struct packed {
    logic bad1;
    logic bad2;
    logic evt;
    logic win_open;
  } stat_t;
endpackage

// File: rtl/dmt_regif.sv
module dmt_regif
  import dmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int unsigned DEF_LIMIT = 1000,
  parameter int unsigned DEF_WIN = 100
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  stat_t             stat_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              tmo_i,
  output wr_kind_e          wr_kind_o,
  output logic              on_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CNT_W-1:0]  win_o,
  output logic              cause_o,
  output logic [DATA_W-1:0] rdata_o
);
  wr_kind_e         wr_kind;
  logic             on_q, on_n, ctrl_en;
  logic [CNT_W-1:0] limit_q, win_q, value_n;
  logic             limit_en, win_en;
  logic             cause_q, cause_n, cause_en;

  // write decode
  always_comb begin
    wr_kind = ACC_NONE;
    if (bus_sel && bus_wr) begin
      case (bus_addr)
        OFS_CTRL:      wr_kind = ACC_CTRL_WR;
        OFS_CTRL_CLR:  wr_kind = ACC_CTRL_CLR;
        OFS_CTRL_SET:  wr_kind = ACC_CTRL_SET;
        OFS_PRECLR:    wr_kind = ACC_PRECLR;
        OFS_CLR:       wr_kind = ACC_CLR;
        OFS_LIMIT:     wr_kind = ACC_LIMIT;
        OFS_WIN:       wr_kind = ACC_WIN;
        OFS_CAUSE_CLR: wr_kind = ACC_CAUSE_CLR;
        default:       wr_kind = ACC_NONE;
      endcase
    end
  end

  // next-state logic
  always_comb begin
    ctrl_en = (wr_kind == ACC_CTRL_WR) || (wr_kind == ACC_CTRL_CLR) ||
              (wr_kind == ACC_CTRL_SET);
    case (wr_kind)
      ACC_CTRL_WR:  on_n = bus_wdata[BIT_ON];
      ACC_CTRL_CLR: on_n = on_q & ~bus_wdata[BIT_ON];
      ACC_CTRL_SET: on_n = on_q | bus_wdata[BIT_ON];
      default:      on_n = on_q;
    endcase
    value_n  = bus_wdata[CNT_W-1:0];
    limit_en = (wr_kind == ACC_LIMIT);
    win_en   = (wr_kind == ACC_WIN);
    // a timeout wins over a simultaneous clear request
    cause_en = tmo_i || ((wr_kind == ACC_CAUSE_CLR) && bus_wdata[BIT_CAUSE]);
    cause_n  = tmo_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q    <= 1'b0;
      limit_q <= CNT_W'(DEF_LIMIT);
      win_q   <= CNT_W'(DEF_WIN);
      cause_q <= 1'b0;
    end else begin
      if (ctrl_en)  on_q    <= on_n;
      if (limit_en) limit_q <= value_n;
      if (win_en)   win_q   <= value_n;
      if (cause_en) cause_q <= cause_n;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        OFS_CTRL: rdata_o[BIT_ON] = on_q;
        OFS_STAT: begin
          rdata_o[BIT_WIN]  = stat_i.win_open;
          rdata_o[BIT_EVT]  = stat_i.evt;
          rdata_o[BIT_BAD2] = stat_i.bad2;
          rdata_o[BIT_BAD1] = stat_i.bad1;
        end
        OFS_CNT:   rdata_o = DATA_W'(cnt_i);
        OFS_LIMIT: rdata_o = DATA_W'(limit_q);
        OFS_WIN:   rdata_o = DATA_W'(win_q);
        OFS_CAUSE: rdata_o[BIT_CAUSE] = cause_q;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign wr_kind_o = wr_kind;
  assign on_o      = on_q;
  assign limit_o   = limit_q;
  assign win_o     = win_q;
  assign cause_o   = cause_q;
endmodule

// File: rtl/dmt_keyseq.sv
module dmt_keyseq
  import dmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  logic     on_i,
  input  wr_kind_e wr_kind_i,
  input  logic [7:0] pre_key_i,
  input  logic [7:0] clr_key_i,
  input  logic     win_open_i,
  input  logic     tmo_i,
  output logic     svc_ok_o,
  output logic     bad1_o,
  output logic     bad2_o
);
  logic armed_q, armed_n;
  logic bad1_q, bad1_n;
  logic bad2_q, bad2_n;
  logic seq_en;
  logic svc_ok;

  always_comb begin
    armed_n = armed_q;
    bad1_n  = bad1_q;
    bad2_n  = bad2_q;
    svc_ok  = 1'b0;
    seq_en  = !on_i || tmo_i || (wr_kind_i == ACC_PRECLR) || (wr_kind_i == ACC_CLR);
    if (!on_i) begin
      armed_n = 1'b0;
      bad1_n  = 1'b0;
      bad2_n  = 1'b0;
    end else begin
      case (wr_kind_i)
        ACC_PRECLR: begin
          if (pre_key_i == KEY_PRE) begin
            armed_n = 1'b1;
          end else begin
            armed_n = 1'b0;
            bad1_n  = 1'b1;
          end
        end
        ACC_CLR: begin
          armed_n = 1'b0;
          if ((clr_key_i != KEY_CLR) || !armed_q) begin
            bad1_n = 1'b1;
          end else if (!win_open_i) begin
            bad2_n = 1'b1;
          end else begin
            svc_ok = 1'b1;
          end
        end
        default: begin
          if (tmo_i) armed_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      bad1_q  <= 1'b0;
      bad2_q  <= 1'b0;
    end else if (seq_en) begin
      armed_q <= armed_n;
      bad1_q  <= bad1_n;
      bad2_q  <= bad2_n;
    end
  end

  assign svc_ok_o = svc_ok;
  assign bad1_o   = bad1_q;
  assign bad2_o   = bad2_q;
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             on_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             svc_ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             win_open_o,
  output logic             tmo_o,
  output logic             evt_o,
  output logic             req_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, open_at;
  logic             cnt_en;
  logic             evt_q, evt_n, evt_en;
  logic             req_q;
  logic             hit;

  always_comb begin
    open_at    = (win_i >= limit_i) ? '0 : (limit_i - win_i);
    hit        = on_i && (cnt_q >= limit_i);
    win_open_o = on_i && (cnt_q >= open_at) && (cnt_q < limit_i);
    cnt_en     = on_i || (cnt_q != '0);
    if (!on_i || hit || svc_ok_i) cnt_n = '0;
    else                          cnt_n = cnt_q + 1'b1;
    evt_en = !on_i || hit;
    evt_n  = on_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_n;
      if (evt_en) evt_q <= evt_n;
      req_q <= hit;
    end
  end

  assign cnt_o = cnt_q;
  assign tmo_o = hit;
  assign evt_o = evt_q;
  assign req_o = req_q;
endmodule

// File: rtl/deadman_wdt.sv
module deadman_wdt
  import dmt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int unsigned DEF_LIMIT = 1000,
  parameter int unsigned DEF_WIN = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        timeout_req,
  output logic        reset_cause
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  wr_kind_e         wr_kind_w;
  logic             on_w;
  logic [CNT_W-1:0] limit_w, win_w, cnt_w;
  logic             win_open_w, tmo_w, evt_w, svc_w, bad1_w, bad2_w;
  stat_t            stat_w;

  assign stat_w = '{bad1: bad1_w, bad2: bad2_w, evt: evt_w, win_open: win_open_w};

  dmt_regif #(
    .CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT), .DEF_WIN(DEF_WIN)
  ) u_regif (
    .clk(clk), .rst_ni(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stat_i(stat_w), .cnt_i(cnt_w), .tmo_i(tmo_w),
    .wr_kind_o(wr_kind_w), .on_o(on_w), .limit_o(limit_w), .win_o(win_w),
    .cause_o(reset_cause), .rdata_o(bus_rdata)
  );

  dmt_keyseq u_keyseq (
    .clk(clk), .rst_ni(rst_int_n), .on_i(on_w), .wr_kind_i(wr_kind_w),
    .pre_key_i(bus_wdata[15:8]), .clr_key_i(bus_wdata[7:0]),
    .win_open_i(win_open_w), .tmo_i(tmo_w),
    .svc_ok_o(svc_w), .bad1_o(bad1_w), .bad2_o(bad2_w)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_ni(rst_int_n), .on_i(on_w), .limit_i(limit_w), .win_i(win_w),
    .svc_ok_i(svc_w), .cnt_o(cnt_w), .win_open_o(win_open_w), .tmo_o(tmo_w),
    .evt_o(evt_w), .req_o(timeout_req)
  );
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             on,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit,
  input logic             win_open,
  input logic             svc_ok,
  input logic             bad1,
  input logic             bad2,
  input logic             evt,
  input logic             timeout_req,
  input logic             reset_cause
);
  a_r6_req_sets_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    timeout_req |-> reset_cause);

  a_r6_req_restarts: assert property (@(posedge clk) disable iff (!rst_ni)
    timeout_req |-> (cnt == '0));

  a_r5_window_below_limit: assert property (@(posedge clk) disable iff (!rst_ni)
    win_open |-> (on && (cnt < limit)));

  a_r4_service_zeroes: assert property (@(posedge clk) disable iff (!rst_ni)
    svc_ok |=> (cnt == '0));

  a_r3_off_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    !on |=> ((cnt == '0) && !bad1 && !bad2 && !evt));

  a_r9_bad1_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (on && bad1) |=> bad1);

  a_r9_bad2_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (on && bad2) |=> bad2);

  a_r9_evt_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (on && evt) |=> evt);
endmodule

bind deadman_wdt dmt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_ni(rst_int_n), .on(on_w), .cnt(cnt_w), .limit(limit_w),
  .win_open(win_open_w), .svc_ok(svc_w), .bad1(bad1_w), .bad2(bad2_w),
  .evt(evt_w), .timeout_req(timeout_req), .reset_cause(reset_cause)
);

// File: tb/sim_deadman_wdt.sv
module sim_deadman_wdt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        timeout_req, reset_cause;

  always #5 clk = ~clk;

  deadman_wdt u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timeout_req(timeout_req), .reset_cause(reset_cause)
  );

  int total = 0;
  int bad = 0;
  bit started = 1'b0;
  bit done = 1'b0;

  // reference model state, written from the requirements
  logic        m_on, m_armed, m_b1, m_b2, m_ev, m_cause, m_req;
  logic [31:0] m_cnt, m_lim, m_win;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_open_at();
    return (m_win >= m_lim) ? 32'd0 : (m_lim - m_win);
  endfunction

  function automatic logic model_window();
    return m_on && (m_cnt >= model_open_at()) && (m_cnt < m_lim);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] v;
    v = 32'h0;
    case (a)
      8'h00: v[15] = m_on;
      8'h30: begin v[0] = model_window(); v[5] = m_ev; v[6] = m_b2; v[7] = m_b1; end
      8'h40: v = m_cnt;
      8'h60: v = m_lim;
      8'h70: v = m_win;
      8'h80: v[5] = m_cause;
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic w, hit, wo, svc;
    logic n_on, n_armed, n_b1, n_b2, n_ev, n_cause;
    logic [31:0] n_cnt, n_lim, n_win;
    if (!rst_n) begin
      m_on = 0; m_armed = 0; m_b1 = 0; m_b2 = 0; m_ev = 0; m_cause = 0; m_req = 0;
      m_cnt = 0; m_lim = 32'd1000; m_win = 32'd100;
    end else begin
      w   = bus_sel && bus_wr;
      hit = m_on && (m_cnt >= m_lim);
      wo  = model_window();
      svc = 0;
      n_armed = m_armed; n_b1 = m_b1; n_b2 = m_b2;
      if (!m_on) begin
        n_armed = 0; n_b1 = 0; n_b2 = 0;
      end else if (w && bus_addr == 8'h10) begin
        if (bus_wdata[15:8] == 8'h40) n_armed = 1;
        else begin n_armed = 0; n_b1 = 1; end
      end else if (w && bus_addr == 8'h20) begin
        n_armed = 0;
        if (bus_wdata[7:0] != 8'h08 || !m_armed) n_b1 = 1;
        else if (!wo) n_b2 = 1;
        else svc = 1;
      end else if (hit) begin
        n_armed = 0;
      end
      n_cnt = (!m_on || hit || svc) ? 32'd0 : m_cnt + 1;
      n_ev  = m_on && (m_ev || hit);
      n_on  = m_on;
      if (w && bus_addr == 8'h00) n_on = bus_wdata[15];
      if (w && bus_addr == 8'h04 && bus_wdata[15]) n_on = 0;
      if (w && bus_addr == 8'h08 && bus_wdata[15]) n_on = 1;
      n_lim = (w && bus_addr == 8'h60) ? bus_wdata : m_lim;
      n_win = (w && bus_addr == 8'h70) ? bus_wdata : m_win;
      n_cause = hit ? 1'b1 : ((w && bus_addr == 8'h84 && bus_wdata[5]) ? 1'b0 : m_cause);
      m_req = hit;
      m_on = n_on; m_armed = n_armed; m_b1 = n_b1; m_b2 = n_b2; m_ev = n_ev;
      m_cause = n_cause; m_cnt = n_cnt; m_lim = n_lim; m_win = n_win;
    end
  end

  // output monitor: reset pulse (R6) and cause flag (R11)
  always @(negedge clk) begin
    if (started) begin
      if (m_req || timeout_req) check("R6 timeout_req pulse", {31'b0, timeout_req}, {31'b0, m_req});
      if (reset_cause !== m_cause) check("R11 reset_cause pin", {31'b0, reset_cause}, {31'b0, m_cause});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp_rd(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [31:0] target);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h40, v);
      if (v >= target) break;
    end
  endtask

  task automatic restart();
    wr(8'h04, 32'h8000);
    wr(8'h08, 32'h8000);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, a, b;
    void'($urandom(32'd20240611));
    idle(4);
    rst_n = 1;
    idle(5);
    started = 1;

    // R1 reset state
    rd(8'h00, v); check("R1 control after reset", v, 32'h0);
    rd(8'h40, v); check("R1 counter after reset", v, 32'h0);
    rd(8'h30, v); check("R1 status after reset", v, 32'h0);
    rd(8'h60, v); check("R1 limit after reset", v, 32'd1000);
    rd(8'h70, v); check("R1 window after reset", v, 32'd100);
    rd(8'h80, v); check("R1 cause after reset", v, 32'h0);
    check("R1 timeout_req after reset", {31'b0, timeout_req}, 32'h0);

    // R12 limit and window read back
    wr(8'h60, 32'hA5A5_0F0F); rd(8'h60, v); check("R12 limit full width", v, 32'hA5A5_0F0F);
    wr(8'h60, 32'd40); rd(8'h60, v); check("R12 limit", v, 32'd40);
    wr(8'h70, 32'd10); rd(8'h70, v); check("R12 window", v, 32'd10);

    // R2 control aliases
    wr(8'h08, 32'h8000); rd(8'h00, v); check("R2 set alias", v, 32'h8000);
    wr(8'h08, 32'h0000); rd(8'h00, v); check("R2 set alias zero no effect", v, 32'h8000);
    wr(8'h04, 32'h0000); rd(8'h00, v); check("R2 clear alias zero no effect", v, 32'h8000);
    wr(8'h04, 32'h8000); rd(8'h00, v); check("R2 clear alias", v, 32'h0);
    wr(8'h00, 32'h8000); rd(8'h00, v); check("R2 direct write", v, 32'h8000);

    // R3 counting
    restart();
    rd(8'h40, a); rd(8'h40, b);
    check("R3 count step", b - a, 32'd1);
    check("R3 count model", b, exp_rd(8'h40));

    // R4 valid service
    restart();
    wr(8'h10, 32'h4000);
    wait_cnt(32'd31);
    rdchk("R5 window open model", 8'h30);
    wr(8'h20, 32'h08);
    rd(8'h40, v); check("R4 counter after service", v, 32'd1);
    rd(8'h30, v); check("R4 no flag after service", v, 32'h0);

    // R8 early clear
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    rd(8'h30, v); check("R8 early clear flag", v, 32'h40);
    rdchk("R8 counter not reset", 8'h40);

    // R9 flag survives a later valid service
    wr(8'h10, 32'h4000);
    wait_cnt(32'd31);
    wr(8'h20, 32'h08);
    rd(8'h30, v); check("R9 bad2 sticky over service", v, 32'h40);

    // R3 disable clears
    wr(8'h04, 32'h8000);
    rd(8'h30, v); check("R3 status cleared on disable", v, 32'h0);
    rd(8'h40, v); check("R3 counter cleared on disable", v, 32'h0);

    // R7 bad sequences
    wr(8'h08, 32'h8000);
    wr(8'h20, 32'h08);
    rd(8'h30, v); check("R7 clear without pre-clear", v, 32'h80);
    rdchk("R7 counter not reset", 8'h40);
    restart();
    wr(8'h10, 32'h4100);
    rd(8'h30, v); check("R7 wrong pre-clear key", v, 32'h80);
    restart();
    wr(8'h10, 32'h4000);
    wait_cnt(32'd31);
    wr(8'h20, 32'h09);
    rd(8'h30, v); check("R7 wrong clear key", v & 32'hC0, 32'h80);
    rdchk("R7 status model", 8'h30);

    // R10 writes while off ignored
    wr(8'h04, 32'h8000);
    wr(8'h10, 32'h4000);
    wr(8'h20, 32'h08);
    rd(8'h30, v); check("R10 no flag while off", v, 32'h0);
    wr(8'h08, 32'h8000);
    wait_cnt(32'd31);
    wr(8'h20, 32'h08);
    rd(8'h30, v); check("R10 pre-clear while off not armed", v & 32'h80, 32'h80);

    // R6 timeout
    restart();
    idle(45);
    rd(8'h30, v); check("R6 event flag", v & 32'h20, 32'h20);
    rd(8'h80, v); check("R6 cause word", v, 32'h20);
    rdchk("R6 counter restarted", 8'h40);

    // R11 cause clear rules
    wr(8'h84, 32'h0); rd(8'h80, v); check("R11 clear with bit low keeps", v, 32'h20);
    wr(8'h04, 32'h8000); rd(8'h80, v); check("R11 survives disable", v, 32'h20);
    wr(8'h84, 32'h20); rd(8'h80, v); check("R11 clear alias", v, 32'h0);

    // R5 window wider than limit
    wr(8'h70, 32'd50);
    wr(8'h08, 32'h8000);
    rd(8'h30, v); check("R5 window clamped to zero", v, 32'h1);
    wr(8'h70, 32'd10);

    // seeded random mix against the model
    for (int it = 0; it < 250; it++) begin
      int op;
      if (it % 40 == 0) begin
        logic [31:0] lim;
        lim = 20 + ($urandom % 60);
        wr(8'h60, lim);
        wr(8'h70, $urandom % (lim + 5));
        restart();
      end
      op = $urandom % 8;
      case (op)
        0: idle(1 + ($urandom % 20));
        1: wr(8'h10, 32'h4000);
        2: wr(8'h20, 32'h08);
        3: begin wr(8'h10, 32'h4000); idle($urandom % 40); wr(8'h20, 32'h08); end
        4: wr(8'h20, {24'h0, 8'($urandom)});
        5: restart();
        6: wr(8'h84, 32'h20);
        default: wr(8'h10, {16'h0, 8'($urandom), 8'h00});
      endcase
      rdchk("R3 random counter", 8'h40);
      rdchk("R9 random status", 8'h30);
      rdchk("R11 random cause", 8'h80);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule